// File: doc/BRIEF.md
# Bitplane Fetch Window Sequencer

This block decides on which memory cycles of a scanline the display fetches bitplane words, and which word it fetches. Each fetch returns one 16-pixel word for one plane. Fetch placement comes from a pair of fetch start and stop cycle registers. These are independent of the horizontal display window: one cycle unit of fetch start equals two low-resolution pixels, so moving the fetch window by 8 cycles moves the fetched image by 16 pixels. A fetch slot opens every 8 memory cycles, starting at the start cycle. Every slot that opens at or before the stop cycle carries one word for each active plane, on consecutive cycles.

The block keeps one word address pointer per plane. The pointer steps by one after each fetch of its plane. At the boundary to the next line, a signed 16-bit modulo is added, which lets software make the words fetched per line fit a wider stored image. The whole line is suppressed when the vertical window flag is low at the start of that line. An external horizontal cycle counter drives the block, and cycle 0 marks the line boundary. Requests go to a memory arbiter that has a fixed read latency, and a per-plane ready strobe reports when each word arrives.

Register values are captured at cycle 0 of each line. Pointer loads are staged and also take effect at a line boundary, so software may write at any time without disturbing a line in progress.

Top module: `bitplane_fetch_seq`

## Requirements
- R1: While reset is asserted and after it, until the first fetch, fetchReq is 0, fetchAddr is 0 and wordReady is all zeros.
- R2: A line fetches only if lineValid is 1 in the cycle where hpos is 0. The cycle with hpos 0 never carries a fetch.
- R3: Slots open at hpos = start + 8k, for every slot whose opening cycle is at or before stop. Plane p (numbered from 0) is fetched at slot opening + p, for each p below the active plane count. A plane count above NUM_PLANES is treated as NUM_PLANES.
- R4: The decision for the hpos presented in a cycle shows on fetchReq, fetchPlane and fetchAddr after the next rising edge. fetchAddr equals the current pointer of that plane. Every slot begins with plane 0.
- R5: A plane's pointer increments by exactly one word after each fetch of that plane.
- R6: If stop is below start, the line makes no fetches.
- R7: At hpos 0, every plane pointer adds the sign-extended 16-bit modulo of the line just ended, if that line was fetching. This holds even when that line made zero fetches. No modulo is added after a suppressed line.
- R8: fetchStartReg, fetchStopReg, planeCount and lineModulo are captured at hpos 0. Changes during a line do not affect that line.
- R9: A pointer write (ptrWrSel names the plane) is held until the next hpos-0 cycle. That cycle's load replaces the plane's pointer and wins over the modulo. A write presented in an hpos-0 cycle waits for the following line. The last write before the boundary wins.
- R10: wordReady has bit p high for one cycle, RD_LAT cycles after a fetchReq for plane p. At most one bit is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory cycle clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hpos | input | CYC_W | Horizontal memory cycle counter, 0 at line start |
| lineValid | input | 1 | Vertical window flag, sampled at hpos 0 |
| fetchStartReg | input | CYC_W | First fetch slot cycle |
| fetchStopReg | input | CYC_W | Last cycle at which a slot may open |
| planeCount | input | PCNT_W | Number of active planes |
| lineModulo | input | 16 | Two's-complement per-line pointer adjustment |
| ptrWrEn | input | 1 | Pointer write strobe |
| ptrWrSel | input | 3 | Plane selected for the pointer write |
| ptrWrData | input | ADDR_W | New word address for the selected plane |
| fetchReq | output | 1 | Fetch request to the memory arbiter |
| fetchPlane | output | 3 | Plane of the current request |
| fetchAddr | output | ADDR_W | Word address of the current request, 0 when idle |
| wordReady | output | NUM_PLANES | Per-plane strobe that a fetched word has arrived |

## Verification
Two things can land on the same pointer in the line-boundary cycle: the end-of-line modulo addition and a staged pointer load. A third case is a pointer write that arrives in that very cycle. The bench writes plane 0 in the middle of an active line, so its load must replace the pending modulo, and writes plane 1 exactly at hpos 0, so its load must be deferred by one line. The first addresses fetched for each plane on the next lines are compared against hand-computed values. A per-cycle reference model also compares every request.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  // Fetch slots repeat every SLOT_LEN memory cycles; planes share one slot.
  localparam int SLOT_LEN = 8;
  localparam int SLOT_W   = 3;

  typedef logic [SLOT_W-1:0] planeIdx_t;

  // Strobes from the control half to the datapath half.
  typedef struct packed {
    logic      lineStart;  // hpos is 0: boundary work happens this cycle
    logic      applyMod;   // line just ended was fetching: add modulo
    logic      fetchHit;   // a fetch happens for the plane below
    planeIdx_t plane;
  } seqStrobe_t;
endpackage

// File: rtl/bpf_fetch_ctrl.sv
module bpf_fetch_ctrl
  import bpf_pkg::*;
#(
  parameter int CYC_W      = 8,
  parameter int NUM_PLANES = 6,
  parameter int PCNT_W     = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CYC_W-1:0]  hpos,
  input  logic              lineValid,
  input  logic [CYC_W-1:0]  fetchStartReg,
  input  logic [CYC_W-1:0]  fetchStopReg,
  input  logic [PCNT_W-1:0] planeCount,
  input  logic [15:0]       lineModulo,
  output seqStrobe_t        strobe,
  output logic [15:0]       curModulo
);
  localparam int CMP_W = PCNT_W + SLOT_W;
  localparam logic [PCNT_W-1:0] PLANE_MAX = PCNT_W'(NUM_PLANES);

  // Per-line copies of the registers, captured at the line boundary.
  logic [CYC_W-1:0]  shStart;
  logic [CYC_W-1:0]  shStop;
  logic [PCNT_W-1:0] shPlanes;
  logic [15:0]       shMod;
  logic              lineOn;

  logic              lineStart;
  logic              afterStart;
  logic              slotOpen;
  logic              phaseOk;
  planeIdx_t         phase;
  logic [CYC_W-1:0]  slotBase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shStart  <= '0;
      shStop   <= '0;
      shPlanes <= '0;
      shMod    <= '0;
      lineOn   <= 1'b0;
    end else if (lineStart) begin
      shStart  <= fetchStartReg;
      shStop   <= fetchStopReg;
      shPlanes <= (planeCount > PLANE_MAX) ? PLANE_MAX : planeCount;
      shMod    <= lineModulo;
      lineOn   <= lineValid;
    end
  end

  always_comb begin
    lineStart  = (hpos == '0);
    phase      = SLOT_W'(hpos - shStart);
    slotBase   = hpos - CYC_W'(phase);
    afterStart = (hpos >= shStart);
    slotOpen   = (slotBase <= shStop);
    phaseOk    = (CMP_W'(phase) < CMP_W'(shPlanes));

    strobe.lineStart = lineStart;
    strobe.applyMod  = lineStart && lineOn;
    strobe.fetchHit  = !lineStart && lineOn && afterStart && slotOpen && phaseOk;
    strobe.plane     = phase;
    curModulo        = shMod;
  end
endmodule

// File: rtl/bpf_fetch_dp.sv
module bpf_fetch_dp
  import bpf_pkg::*;
#(
  parameter int NUM_PLANES = 6,
  parameter int ADDR_W     = 20,
  parameter int RD_LAT     = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  seqStrobe_t            strobe,
  input  logic [15:0]           curModulo,
  input  logic                  ptrWrEn,
  input  planeIdx_t             ptrWrSel,
  input  logic [ADDR_W-1:0]     ptrWrData,
  output logic                  fetchReq,
  output planeIdx_t             fetchPlane,
  output logic [ADDR_W-1:0]     fetchAddr,
  output logic [NUM_PLANES-1:0] wordReady
);
  logic [ADDR_W-1:0] modExt;
  assign modExt = {{(ADDR_W-16){curModulo[15]}}, curModulo};

  logic [NUM_PLANES-1:0][ADDR_W-1:0] ptrAll;

  // One pointer lane per plane with its own staged load.
  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_lane
    logic [ADDR_W-1:0] ptrQ;
    logic [ADDR_W-1:0] pendQ;
    logic              pendV;
    logic              isFetch;
    logic              isWrite;

    assign isFetch = strobe.fetchHit && (strobe.plane == SLOT_W'(p));
    assign isWrite = ptrWrEn && (ptrWrSel == SLOT_W'(p));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ptrQ  <= '0;
        pendQ <= '0;
        pendV <= 1'b0;
      end else begin
        if (strobe.lineStart) begin
          if (pendV)                ptrQ <= pendQ;
          else if (strobe.applyMod) ptrQ <= ptrQ + modExt;
        end else if (isFetch) begin
          ptrQ <= ptrQ + ADDR_W'(1);
        end
        if (strobe.lineStart) pendV <= 1'b0;
        if (isWrite) begin
          pendQ <= ptrWrData;
          pendV <= 1'b1;
        end
      end
    end

    assign ptrAll[p] = ptrQ;
  end

  logic [ADDR_W-1:0]     selAddr;
  logic [NUM_PLANES-1:0] hitVec;

  always_comb begin
    selAddr = '0;
    hitVec  = '0;
    for (int i = 0; i < NUM_PLANES; i++) begin
      if (strobe.plane == SLOT_W'(i)) begin
        selAddr = ptrAll[i];
        hitVec[i] = strobe.fetchHit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchReq   <= 1'b0;
      fetchPlane <= '0;
      fetchAddr  <= '0;
    end else begin
      fetchReq   <= strobe.fetchHit;
      fetchPlane <= strobe.fetchHit ? strobe.plane : '0;
      fetchAddr  <= strobe.fetchHit ? selAddr : '0;
    end
  end

  // Arrival strobes: the request vector delayed by the arbiter latency.
  logic [NUM_PLANES-1:0] rdyPipe [RD_LAT+1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s <= RD_LAT; s++) rdyPipe[s] <= '0;
    end else begin
      rdyPipe[0] <= hitVec;
      for (int s = RD_LAT; s > 0; s--) rdyPipe[s] <= rdyPipe[s-1];
    end
  end

  assign wordReady = rdyPipe[RD_LAT];
endmodule

// File: rtl/bitplane_fetch_seq.sv
module bitplane_fetch_seq #(
  parameter int CYC_W      = 8,
  parameter int NUM_PLANES = 6,
  parameter int ADDR_W     = 20,
  parameter int RD_LAT     = 2,
  parameter int PCNT_W     = $clog2(NUM_PLANES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CYC_W-1:0]             hpos,
  input  logic                         lineValid,
  input  logic [CYC_W-1:0]             fetchStartReg,
  input  logic [CYC_W-1:0]             fetchStopReg,
  input  logic [PCNT_W-1:0]            planeCount,
  input  logic [15:0]                  lineModulo,
  input  logic                         ptrWrEn,
  input  logic [bpf_pkg::SLOT_W-1:0]   ptrWrSel,
  input  logic [ADDR_W-1:0]            ptrWrData,
  output logic                         fetchReq,
  output logic [bpf_pkg::SLOT_W-1:0]   fetchPlane,
  output logic [ADDR_W-1:0]            fetchAddr,
  output logic [NUM_PLANES-1:0]        wordReady
);
  bpf_pkg::seqStrobe_t seqStrobe;
  logic [15:0]         curModulo;

  bpf_fetch_ctrl #(
    .CYC_W(CYC_W), .NUM_PLANES(NUM_PLANES), .PCNT_W(PCNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .hpos(hpos), .lineValid(lineValid),
    .fetchStartReg(fetchStartReg), .fetchStopReg(fetchStopReg),
    .planeCount(planeCount), .lineModulo(lineModulo),
    .strobe(seqStrobe), .curModulo(curModulo)
  );

  bpf_fetch_dp #(
    .NUM_PLANES(NUM_PLANES), .ADDR_W(ADDR_W), .RD_LAT(RD_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(seqStrobe), .curModulo(curModulo),
    .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .fetchReq(fetchReq), .fetchPlane(fetchPlane), .fetchAddr(fetchAddr),
    .wordReady(wordReady)
  );
endmodule

// File: rtl/bitplane_fetch_seq_chk.sv
module bitplane_fetch_seq_chk #(
  parameter int CYC_W      = 8,
  parameter int NUM_PLANES = 6
) (
  input logic                       clk,
  input logic                       rstN,
  input logic [CYC_W-1:0]           hpos,
  input logic                       lineValid,
  input logic                       fetchReq,
  input logic [bpf_pkg::SLOT_W-1:0] fetchPlane,
  input logic [NUM_PLANES-1:0]      wordReady
);
  // Observed vertical window state of the current line.
  logic cLineOn;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cLineOn <= 1'b0;
    else if (hpos == '0)  cLineOn <= lineValid;
  end

  a_r2_cycle0_idle: assert property (@(posedge clk) disable iff (!rstN)
    ($past(hpos) == '0) |-> !fetchReq);

  a_r2_line_gate: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> $past(cLineOn));

  a_r3_plane_range: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |-> (int'(fetchPlane) < NUM_PLANES));

  a_r3_plane_sequence: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && $past(fetchReq)) |->
      (fetchPlane == bpf_pkg::SLOT_W'($past(fetchPlane) + 1'b1)));

  a_r4_slot_opens_plane0: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fetchReq) |-> (fetchPlane == '0));

  a_r10_ready_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wordReady));
endmodule

bind bitplane_fetch_seq bitplane_fetch_seq_chk #(
  .CYC_W(CYC_W), .NUM_PLANES(NUM_PLANES)
) u_chk (
  .clk(clk), .rstN(rstN), .hpos(hpos), .lineValid(lineValid),
  .fetchReq(fetchReq), .fetchPlane(fetchPlane), .wordReady(wordReady)
);

// File: tb/bitplane_fetch_seq_bench.sv
module bitplane_fetch_seq_bench;
  localparam int CYC_W = 8, NP = 6, AW = 20, LAT = 2, PW = 3;
  localparam int LINE_LEN = 100;
  localparam int NLINES = 8;
  localparam int unsigned AMASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CYC_W-1:0] hpos = '0;
  logic lineValid = 1'b0;
  logic [CYC_W-1:0] regStart = 8'd8, regStop = 8'd40;
  logic [PW-1:0] regPlanes = 3'd2;
  logic [15:0] regMod = 16'd10;
  logic ptrWrEn = 1'b0;
  logic [2:0] ptrWrSel = '0;
  logic [AW-1:0] ptrWrData = '0;
  logic fetchReq;
  logic [2:0] fetchPlane;
  logic [AW-1:0] fetchAddr;
  logic [NP-1:0] wordReady;

  always #10 clk = ~clk;

  bitplane_fetch_seq #(.CYC_W(CYC_W), .NUM_PLANES(NP), .ADDR_W(AW), .RD_LAT(LAT)) u_bitplane_fetch_seq (
    .clk(clk), .rstN(rstN), .hpos(hpos), .lineValid(lineValid),
    .fetchStartReg(regStart), .fetchStopReg(regStop), .planeCount(regPlanes),
    .lineModulo(regMod), .ptrWrEn(ptrWrEn), .ptrWrSel(ptrWrSel), .ptrWrData(ptrWrData),
    .fetchReq(fetchReq), .fetchPlane(fetchPlane), .fetchAddr(fetchAddr), .wordReady(wordReady));

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int unsigned mPtr[NP], mPend[NP];
  bit mPendV[NP];
  bit mActive = 0;
  int sStart = 0, sStop = 0, sPlanes = 0, sMod = 0;
  bit expReq = 0;
  int expPlane = 0;
  int unsigned expAddr = 0;
  logic [NP-1:0] rdyH [0:LAT];

  // Per-line observations
  int lineCnt[NLINES];
  int unsigned firstAddr[NLINES][NP];
  bit firstSeen[NLINES][NP];
  int prevLine = -1, curLine = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic sampleAndCompare();
    check(fetchReq == expReq, "R4", "fetchReq", fetchReq, expReq);
    if (expReq) begin
      check(fetchPlane == 3'(expPlane), "R4", "fetchPlane", fetchPlane, expPlane);
      check(fetchAddr == AW'(expAddr), "R5", "fetchAddr", fetchAddr, expAddr);
    end
    check(wordReady == rdyH[LAT], "R10", "wordReady", wordReady, rdyH[LAT]);
    if (prevLine >= 0 && fetchReq) begin
      lineCnt[prevLine]++;
      if (int'(fetchPlane) < NP && !firstSeen[prevLine][fetchPlane]) begin
        firstSeen[prevLine][fetchPlane] = 1;
        firstAddr[prevLine][fetchPlane] = fetchAddr;
      end
    end
  endtask

  task automatic modelStep(int h, bit lv, bit wEn, int wSel, int unsigned wData);
    logic [NP-1:0] hot = '0;
    expReq = 0; expPlane = 0; expAddr = 0;
    if (h != 0 && mActive && h >= sStart) begin
      int p = (h - sStart) % 8;
      if (h - p <= sStop && p < sPlanes) begin
        expReq = 1; expPlane = p; expAddr = mPtr[p];
        mPtr[p] = (mPtr[p] + 1) & AMASK;
        hot[p] = 1'b1;
      end
    end
    if (h == 0) begin
      for (int p = 0; p < NP; p++) begin
        if (mPendV[p]) mPtr[p] = mPend[p];
        else if (mActive) mPtr[p] = (mPtr[p] + sMod) & AMASK;
        mPendV[p] = 0;
      end
      sStart = regStart; sStop = regStop;
      sPlanes = (regPlanes > NP) ? NP : regPlanes;
      sMod = int'($signed(regMod));
      mActive = lv;
    end
    if (wEn) begin mPend[wSel] = wData; mPendV[wSel] = 1; end
    for (int s = LAT; s > 0; s--) rdyH[s] = rdyH[s-1];
    rdyH[0] = hot;
  endtask

  task automatic runLine(bit lv, bit initPtrs, int wrAt, int wrSel, int unsigned wrData, bit midChange);
    for (int h = 0; h < LINE_LEN; h++) begin
      @(negedge clk);
      sampleAndCompare();
      hpos = CYC_W'(h); lineValid = lv; ptrWrEn = 0;
      if (initPtrs && h >= 10 && h < 10 + NP) begin
        ptrWrEn = 1; ptrWrSel = 3'(h - 10); ptrWrData = AW'(32'h1000 * (h - 9));
      end
      if (h == wrAt) begin ptrWrEn = 1; ptrWrSel = 3'(wrSel); ptrWrData = AW'(wrData); end
      if (midChange && h == 50) begin regStop = 8'd99; regMod = 16'd77; end
      modelStep(h, lv, ptrWrEn, ptrWrSel, ptrWrData);
      prevLine = curLine;
    end
    curLine++;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int p = 0; p < NP; p++) begin mPtr[p] = 0; mPend[p] = 0; mPendV[p] = 0; end
    for (int s = 0; s <= LAT; s++) rdyH[s] = '0;
    for (int l = 0; l < NLINES; l++) begin
      lineCnt[l] = 0;
      for (int p = 0; p < NP; p++) begin firstSeen[l][p] = 0; firstAddr[l][p] = 0; end
    end
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    check(fetchReq == 0, "R1", "fetchReq in reset", fetchReq, 0);
    check(fetchAddr == 0, "R1", "fetchAddr in reset", fetchAddr, 0);
    check(wordReady == 0, "R1", "wordReady in reset", wordReady, 0);
    rstN = 1;
    modelStep(0, 0, 0, 0, 0);

    runLine(0, 1, -1, 0, 0, 0);                                  // L0 suppressed, pointers staged
    runLine(1, 0, -1, 0, 0, 0);                                  // L1
    regStart = 8'd4; regStop = 8'd3; regPlanes = 3'd6; regMod = 16'hFFFD;
    runLine(1, 0, -1, 0, 0, 1);                                  // L2 stop<start, mid-line edits
    regStart = 8'd20; regStop = 8'd36; regPlanes = 3'd7; regMod = 16'd0;
    runLine(1, 0, 30, 0, 32'h8000, 0);                           // L3 clamp, plane 0 write
    regPlanes = 3'd1; regMod = 16'd100;
    runLine(1, 0, 0, 1, 32'h9000, 0);                            // L4 write at hpos 0
    regStop = 8'd20; regPlanes = 3'd2;
    runLine(1, 0, -1, 0, 0, 0);                                  // L5
    runLine(0, 0, -1, 0, 0, 0);                                  // L6 suppressed
    runLine(1, 0, -1, 0, 0, 0);                                  // L7
    @(negedge clk);
    sampleAndCompare();

    check(lineCnt[0] == 0, "R2", "fetches on suppressed line 0", lineCnt[0], 0);
    check(lineCnt[1] == 10, "R3", "fetches on line 1", lineCnt[1], 10);
    check(firstAddr[1][0] == 'h1000, "R9", "line 1 plane 0 start", firstAddr[1][0], 'h1000);
    check(firstAddr[1][1] == 'h2000, "R9", "line 1 plane 1 start", firstAddr[1][1], 'h2000);
    check(lineCnt[2] == 0, "R6", "fetches with stop<start (R8 edits ignored)", lineCnt[2], 0);
    check(firstAddr[3][0] == 'h100C, "R7", "modulo after zero-fetch line", firstAddr[3][0], 'h100C);
    check(firstAddr[3][5] == 'h6007, "R3", "clamped plane 5 start", firstAddr[3][5], 'h6007);
    check(lineCnt[3] == 18, "R3", "fetches with clamped planes", lineCnt[3], 18);
    check(firstAddr[4][0] == 'h8000, "R9", "staged load wins over modulo", firstAddr[4][0], 'h8000);
    check(lineCnt[4] == 3, "R3", "fetches on line 4", lineCnt[4], 3);
    check(firstAddr[5][1] == 'h9000, "R9", "hpos-0 write deferred a line", firstAddr[5][1], 'h9000);
    check(firstAddr[5][0] == 'h8067, "R7", "modulo on line 5", firstAddr[5][0], 'h8067);
    check(lineCnt[6] == 0, "R2", "fetches on suppressed line 6", lineCnt[6], 0);
    check(firstAddr[7][0] == 'h80CC, "R7", "no modulo after suppressed line", firstAddr[7][0], 'h80CC);
    check(lineCnt[7] == 2, "R3", "fetches on line 7", lineCnt[7], 2);
    done = 1;
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end
endmodule